// File: doc/BRIEF.md
# Fixed-Latency Interrupt Entry Sequencer

This block sits in front of a single-issue core that retires one instruction per clock. It takes an asynchronous external interrupt pin and an on-chip interrupt request, such as a timer overflow. For each accepted request it runs one entry sequence of fixed length: it asks the core to clear its pipeline, then issues a one-clock vector-fetch strobe together with the identity of the source. Every request is aligned to a single clock boundary before any decision is made. The delay from request to vector therefore never depends on when the event arrived, or on whether the instruction in flight takes one cycle or two.

The external pin passes through a synchronizer chain and a rising-edge detector, which costs two clocks. The internal request bypasses the synchronizer. Both sources feed sticky pending flags. A flag is consumed at the clock edge where the sequencer captures that source. If both sources are eligible on the same edge, the internal one is taken first. A global enable holds entry back while it is low, but requests are still recorded during that time.

Top module: `irq_entry_seq`

## Requirements
- R1: A synchronous active-high reset clears both pending flags and returns the sequencer to idle. `flush` and `vec_fetch` are 0 on the first cycle after reset. A pin that is already high while reset is asserted does not count as an edge.
- R2: If `int_req` is sampled high at rising edge t while idle and enabled, `vec_fetch` is high in the cycle after edge t+2. This is a latency of 3 clocks counting edge t.
- R3: If `ext_pin` is first sampled high at edge k after being low, `vec_fetch` is high in the cycle after edge k+4. This is 5 clocks: 2 for synchronization and 3 for entry.
- R4: `two_cycle_busy` has no effect on the timing or on the outputs. The latencies of R2 and R3 hold whether it is high or low.
- R5: `flush` is high for exactly the two cycles that come before the `vec_fetch` cycle. `vec_fetch` is high for exactly one cycle. The two outputs are never high together.
- R6: `vec_src` is valid while `vec_fetch` is high. The encoding is 0 for the internal source and 1 for the external source.
- R7: If both sources are eligible at the same edge, the internal one is served first. The external one stays pending. Its entry starts on the first edge at which the sequencer is idle, so its vector comes 4 clocks after the internal vector.
- R8: While `irq_en` is low, no entry starts and requests are kept pending. If `irq_en` is sampled high at edge e while a request is pending, entry starts at edge e and `vec_fetch` is high in the cycle after edge e+2.
- R9: A request that arrives during an entry sequence neither restarts nor lengthens that sequence. It is served after the sequencer returns to idle.
- R10: Only a rising edge of the pin is an event. A pin held high for many clocks produces exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| int_req | input | 1 | On-chip interrupt request, sampled each clock |
| two_cycle_busy | input | 1 | Marks a two-cycle instruction in progress; has no effect on timing |
| flush | output | 1 | Pipeline clear request, high during the two entry cycles before the vector |
| vec_fetch | output | 1 | One-clock vector fetch strobe |
| vec_src | output | 1 | Source of the vector: 0 internal, 1 external |

## Verification
A wrong sequencer phase shows up at the ports within the same entry. The vector strobe moves by at least one clock from its required position relative to the sampling edge, or the flush pair is no longer directly in front of it. A pending flag that is lost or stuck appears a few clocks later. In the first case the second vector of a simultaneous or overlapping pair never arrives. In the second case an extra vector appears after the sequencer returns to idle. An edge detector error appears as a missing vector after a fresh pin rise, or as extra vectors while the pin is held high or was high through reset.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CLEAR_A = 2'd1,
    PH_CLEAR_B = 2'd2,
    PH_VECTOR  = 2'd3
  } phase_e;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  // stages 0..SYNC_STAGES-1 synchronize, the last stage holds history
  logic [CHAIN_LEN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;  // all ones: a pin high through reset is no edge
    else     chain_q <= {chain_q[CHAIN_LEN-2:0], pin};
  end

  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R3: a detected edge reflects the pin level seen SYNC_STAGES edges ago
  assert_rise_follows_pin_R3: assert property (@(posedge clk) disable iff (rst)
    (rise && SYNC_STAGES == 2) |-> $past(pin, 2));
  // R10: one event per rising edge, never two in a row
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic clk,
  input  logic rst,
  input  logic ext_rise,
  input  logic int_req,
  input  logic take_int,
  input  logic take_ext,
  output logic int_elig,
  output logic ext_elig
);
  logic int_pend_q, ext_pend_q;

  assign int_elig = int_pend_q | int_req;
  assign ext_elig = ext_pend_q | ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_pend_q <= 1'b0;
      ext_pend_q <= 1'b0;
    end else begin
      int_pend_q <= int_elig & ~take_int;
      ext_pend_q <= ext_elig & ~take_ext;
    end
  end

  // R7: the losing external request survives the internal win
  assert_ext_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (take_int && ext_elig) |=> ext_elig);
  // R6: a single source is captured per edge
  assert_one_take_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_int, take_ext}));
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic int_elig,
  input  logic ext_elig,
  output logic take_int,
  output logic take_ext,
  output logic seq_busy,
  output logic flush,
  output logic vec_fetch,
  output src_e vec_src
);
  phase_e phase_q, phase_d;
  logic   start;
  logic   flush_q, vec_q;
  src_e   src_q;

  assign start    = (phase_q == PH_IDLE) & en & (int_elig | ext_elig);
  assign take_int = start & int_elig;
  assign take_ext = start & ~int_elig & ext_elig;
  assign seq_busy = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start) phase_d = PH_CLEAR_A;
      PH_CLEAR_A: phase_d = PH_CLEAR_B;
      PH_CLEAR_B: phase_d = PH_VECTOR;
      PH_VECTOR:  phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      flush_q <= 1'b0;
      vec_q   <= 1'b0;
      src_q   <= SRC_INT;
    end else begin
      phase_q <= phase_d;
      flush_q <= (phase_d == PH_CLEAR_A) || (phase_d == PH_CLEAR_B);
      vec_q   <= (phase_d == PH_VECTOR);
      if (start) src_q <= int_elig ? SRC_INT : SRC_EXT;
    end
  end

  assign flush     = flush_q;
  assign vec_fetch = vec_q;
  assign vec_src   = src_q;

  // R5: clearing begins right after capture
  assert_flush_after_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> flush);
  // R2: fixed distance from capture to vector
  assert_vector_timing_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> ##3 vec_fetch);
  // R5: vector only directly behind a flush cycle
  assert_vector_after_flush_R5: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> $past(flush));
  // R5: outputs exclusive
  assert_outputs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flush, vec_fetch}));
  // R9: a running sequence is never stretched
  assert_no_stretch_R9: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_fetch);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic ext_pin,
  input  logic int_req,
  input  logic two_cycle_busy,
  output logic flush,
  output logic vec_fetch,
  output logic vec_src
);
  import irq_seq_pkg::*;

  logic ext_rise, int_elig, ext_elig, take_int, take_ext, seq_busy;
  src_e src_w;

  irq_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .pin (ext_pin),
    .rise(ext_rise)
  );

  irq_pending pend_i (
    .clk     (clk),
    .rst     (rst),
    .ext_rise(ext_rise),
    .int_req (int_req),
    .take_int(take_int),
    .take_ext(take_ext),
    .int_elig(int_elig),
    .ext_elig(ext_elig)
  );

  irq_entry_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .en       (irq_en),
    .int_elig (int_elig),
    .ext_elig (ext_elig),
    .take_int (take_int),
    .take_ext (take_ext),
    .seq_busy (seq_busy),
    .flush    (flush),
    .vec_fetch(vec_fetch),
    .vec_src  (src_w)
  );

  assign vec_src = src_w;

  // R4: a two-cycle instruction does not move the vector
  assert_busy_no_shift_R4: assert property (@(posedge clk) disable iff (rst)
    ((take_int || take_ext) && two_cycle_busy) |-> ##3 vec_fetch);
  // R8: with enable low and nothing running, no clearing starts
  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !seq_busy) |=> !flush);
endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_en = 1'b1;
  logic ext_pin = 1'b0;
  logic int_req = 1'b0;
  logic two_cycle_busy = 1'b0;
  logic flush, vec_fetch, vec_src;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  irq_entry_seq dut_i (
    .clk(clk), .rst(rst), .irq_en(irq_en), .ext_pin(ext_pin),
    .int_req(int_req), .two_cycle_busy(two_cycle_busy),
    .flush(flush), .vec_fetch(vec_fetch), .vec_src(vec_src)
  );

  initial forever #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // table: kind 0 internal, 1 external; busy level held during the case
  localparam int NV = 6;
  localparam int KIND [NV] = '{0, 1, 1, 0, 1, 0};
  localparam int BUSY [NV] = '{0, 0, 1, 1, 0, 1};

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // observe n cycles; record first two vector strobes
  task automatic watch(input int n, output int cnt, output int c1, output int s1,
                       output int c2, output int s2);
    cnt = 0; c1 = -1; s1 = -1; c2 = -1; s2 = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vec_fetch) begin
        cnt++;
        if (cnt == 1) begin c1 = cyc; s1 = int'(vec_src); end
        if (cnt == 2) begin c2 = cyc; s2 = int'(vec_src); end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int cnt, c1, s1, c2, s2, t, k, e;
    // R1: pin high across reset is not an edge
    ext_pin = 1'b1;
    do_reset();
    @(negedge clk);
    check("R1 flush after reset", int'(flush), 0);
    check("R1 vec_fetch after reset", int'(vec_fetch), 0);
    watch(8, cnt, c1, s1, c2, s2);
    check("R1 no spurious entry", cnt, 0);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      two_cycle_busy = BUSY[v][0];
      if (KIND[v] == 0) begin
        int_req = 1'b1; t = cyc + 1;
        @(negedge clk); int_req = 1'b0;
      end else begin
        ext_pin = 1'b1; t = cyc + 1;
        repeat (3) @(negedge clk); ext_pin = 1'b0;
      end
      watch(10, cnt, c1, s1, c2, s2);
      check(KIND[v] == 0 ? "R2 R4 internal latency" : "R3 R4 external latency",
            c1 - t + 1, KIND[v] == 0 ? 3 : 5);
      check("R6 vector source", s1, KIND[v]);
      check("R9 single entry", cnt, 1);
      two_cycle_busy = 1'b0;
    end

    // R5: flush shape
    int_req = 1'b1; t = cyc + 1;
    @(negedge clk); int_req = 1'b0;
    check("R5 flush cycle 1", int'(flush), 1);
    check("R5 no vector cycle 1", int'(vec_fetch), 0);
    @(negedge clk);
    check("R5 flush cycle 2", int'(flush), 1);
    @(negedge clk);
    check("R5 flush low at vector", int'(flush), 0);
    check("R5 vector at t+2", int'(vec_fetch), 1);
    @(negedge clk);
    check("R5 vector one clock", int'(vec_fetch), 0);
    repeat (4) @(negedge clk);

    // R7: both eligible at the same edge
    ext_pin = 1'b1; k = cyc + 1;
    @(negedge clk); @(negedge clk);
    int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    watch(10, cnt, c1, s1, c2, s2);
    check("R7 internal first timing", c1 - k, 4);
    check("R7 internal first source", s1, 0);
    check("R7 external next timing", c2 - k, 8);
    check("R7 external next source", s2, 1);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R8: enable gating
    irq_en = 1'b0;
    int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    watch(6, cnt, c1, s1, c2, s2);
    check("R8 no entry while disabled", cnt, 0);
    check("R8 no flush while disabled", int'(flush), 0);
    irq_en = 1'b1; e = cyc + 1;
    watch(6, cnt, c1, s1, c2, s2);
    check("R8 entry after enable", c1 - e, 2);
    check("R8 single pending entry", cnt, 1);
    repeat (3) @(negedge clk);

    // R9: second request during sequence
    int_req = 1'b1; t = cyc + 1;
    @(negedge clk); @(negedge clk); int_req = 1'b0;
    watch(10, cnt, c1, s1, c2, s2);
    check("R9 first vector not stretched", c1 - t, 2);
    check("R9 second vector after idle", c2 - t, 6);
    check("R9 two entries", cnt, 2);
    repeat (3) @(negedge clk);

    // R10: level held high gives one entry
    ext_pin = 1'b1;
    watch(14, cnt, c1, s1, c2, s2);
    check("R10 held pin one entry", cnt, 1);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset drops a pending request
    irq_en = 1'b0;
    int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    do_reset();
    irq_en = 1'b1;
    watch(6, cnt, c1, s1, c2, s2);
    check("R1 pending cleared by reset", cnt, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule